// File: doc/BRIEF.md
# Ring-Protocol Frame Priority Classifier

This block sits in a switch's ingress path and classifies each frame by its EtherType. It takes a stream of 16-bit header words that starts at the first type field after the MAC addresses. It passes over up to two VLAN tags, an outer one and then an inner one, using two programmable tag-type values, and finds the real EtherType. That EtherType is compared in parallel with a programmable ring-protocol value and with two programmable time-sync values.

One registered result comes out per frame, one clock after the word that carries the EtherType. A ring-protocol frame is lifted to the top transmit queue priority (3) when the global ring enable is set. It is also flagged for the dedicated host channel, but only when its destination port is the host port (port 0). A time-sync match sets its own flag whatever the enable is. When a frame matches both kinds, the ring-protocol action applies and the time-sync flag is still raised. The surrounding register file is expected to reset the configuration inputs as follows: ring type 0x80E1, both time-sync types 0x0000, both tag types 0x8100.

Top module: `rpc_classifier`

## Requirements
- R1: While reset is held and after it is released, `res_valid`, `res_prio`, `res_host_chan` and `res_tsync` are all 0 until the first EtherType is classified.
- R2: `res_valid` pulses high for exactly one cycle, one clock after the header word that is recognised as the EtherType, and stays low for every other word.
- R3: With `ring_en` = 0, a frame whose EtherType equals `ring_etype` keeps its `frame_prio` and has `res_host_chan` = 0.
- R4: With `ring_en` = 1, a frame whose EtherType equals `ring_etype` gets `res_prio` = 3.
- R5: With `ring_en` = 1, a ring-protocol frame gets `res_host_chan` = 1 only when its `dest_port` is 0; for any other port the flag is 0.
- R6: A frame whose EtherType matches none of the programmed values gets `res_prio` equal to its `frame_prio`, and both flags are 0.
- R7: `res_tsync` is 1 when the EtherType equals `tsync_etype_a` or `tsync_etype_b`, whatever the value of `ring_en`.
- R8: An EtherType equal to both `ring_etype` and a time-sync value gets the ring-protocol result and `res_tsync` = 1.
- R9: A first type word (the word with `hdr_sof` = 1) equal to `vtag_outer` opens a tag. The word after it is the tag control word and is never compared, and the word after that is the next type field.
- R10: Only the type word that follows an outer tag is compared with `vtag_inner`. A first type word equal to `vtag_inner` but not to `vtag_outer` is taken as the EtherType.
- R11: After two tags, the next type word is always the EtherType, even if it equals a tag type.
- R12: A word with `hdr_sof` = 1 restarts parsing even in the middle of a frame. Words with `hdr_sof` = 0 that arrive when no frame is open produce no result.
- R13: `dest_port` and `frame_prio` are taken from the word that carries `hdr_sof` = 1. Their values on later words of the frame have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hdr_valid | input | 1 | Header word valid |
| hdr_sof | input | 1 | Marks the first type word of a frame |
| hdr_word | input | 16 | Header word (type field or tag control word) |
| dest_port | input | 2 | Destination port of the frame, 0 is the host |
| frame_prio | input | 2 | Priority the frame would get without a match |
| ring_en | input | 1 | Global enable for the ring-protocol action |
| ring_etype | input | 16 | Ring-protocol EtherType to match |
| tsync_etype_a | input | 16 | First time-sync EtherType |
| tsync_etype_b | input | 16 | Second time-sync EtherType |
| vtag_outer | input | 16 | Outer VLAN tag type |
| vtag_inner | input | 16 | Inner VLAN tag type |
| res_valid | output | 1 | Result strobe, one per frame |
| res_prio | output | 2 | Assigned transmit queue priority |
| res_host_chan | output | 1 | Steer to the dedicated host channel |
| res_tsync | output | 1 | Frame is a time-sync frame |

## Verification
The hardest case to reach from the ports is a tag walk in which a tag-type value or the ring-protocol value turns up where it must not be acted on. Examples are inside a tag control word, as the first type of a frame when it only matches the inner tag type, or as the type after two tags. Table frames place these values in exactly those positions. During every non-first word they drive the inverted port and priority, so a result taken from the wrong word is exposed. Directed sequences add a frame restarted in mid-tag, words that arrive after a frame has closed, and a time-sync value made equal to the ring-protocol value.

// File: rtl/rpc_pkg.sv
package rpc_pkg;
   localparam int ETYPE_W = 16;

   // Values the owning register file is expected to load at reset
   localparam logic [ETYPE_W-1:0] RING_ETYPE_RST  = 16'h80E1;
   localparam logic [ETYPE_W-1:0] TSYNC_ETYPE_RST = 16'h0000;
   localparam logic [ETYPE_W-1:0] VTAG_RST        = 16'h8100;

   typedef enum logic {
      WALK_TYPE = 1'b0,
      WALK_TCI  = 1'b1
   } walk_e;
endpackage

// File: rtl/rpc_tag_walker.sv
module rpc_tag_walker
   import rpc_pkg::*;
#(
   parameter int WORD_W     = 16,
   parameter int TAG_LEVELS = 2,
   parameter int PORT_W     = 2,
   parameter int PRIO_W     = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hdr_valid,
   input  logic              hdr_sof,
   input  logic [WORD_W-1:0] hdr_word,
   input  logic [WORD_W-1:0] tag_outer,
   input  logic [WORD_W-1:0] tag_inner,
   input  logic [PORT_W-1:0] in_port,
   input  logic [PRIO_W-1:0] in_prio,
   output logic              et_valid,
   output logic [WORD_W-1:0] et_word,
   output logic [PORT_W-1:0] et_port,
   output logic [PRIO_W-1:0] et_prio
);
   localparam int DEPTH_W = 2;

   if (TAG_LEVELS < 0 || TAG_LEVELS > 2) begin : g_bad_levels
      $error("rpc_tag_walker: TAG_LEVELS must be 0, 1 or 2");
   end

   logic               open_q;
   walk_e              walk_q;
   logic [DEPTH_W-1:0] depth_q;
   logic [PORT_W-1:0]  port_q;
   logic [PRIO_W-1:0]  prio_q;

   logic               take_type;
   logic               take_tci;
   logic [DEPTH_W-1:0] cur_depth;
   logic               tag_hit;

   always_comb begin
      take_type = hdr_valid && (hdr_sof || (open_q && walk_q == WALK_TYPE));
      take_tci  = hdr_valid && !hdr_sof && open_q && walk_q == WALK_TCI;
      cur_depth = hdr_sof ? '0 : depth_q;
   end

   // Tag recognition depth chosen by parameter
   if (TAG_LEVELS == 0) begin : g_no_tags
      assign tag_hit = 1'b0;
   end else if (TAG_LEVELS == 1) begin : g_one_tag
      assign tag_hit = (cur_depth == '0) && (hdr_word == tag_outer);
   end else begin : g_two_tags
      assign tag_hit = ((cur_depth == DEPTH_W'(0)) && (hdr_word == tag_outer)) ||
                       ((cur_depth == DEPTH_W'(1)) && (hdr_word == tag_inner));
   end

   always_comb begin
      et_valid = take_type && !tag_hit;
      et_word  = hdr_word;
      et_port  = hdr_sof ? in_port : port_q;
      et_prio  = hdr_sof ? in_prio : prio_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         open_q  <= 1'b0;
         walk_q  <= WALK_TYPE;
         depth_q <= '0;
         port_q  <= '0;
         prio_q  <= '0;
      end else begin
         if (hdr_valid && hdr_sof) begin
            port_q <= in_port;
            prio_q <= in_prio;
         end
         if (take_type) begin
            if (tag_hit) begin
               open_q  <= 1'b1;
               walk_q  <= WALK_TCI;
               depth_q <= cur_depth + DEPTH_W'(1);
            end else begin
               open_q  <= 1'b0;
               walk_q  <= WALK_TYPE;
               depth_q <= '0;
            end
         end else if (take_tci) begin
            walk_q <= WALK_TYPE;
         end
      end
   end

   AST_DEPTH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      depth_q <= DEPTH_W'(TAG_LEVELS)); // R11
   AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      et_valid |=> (!et_valid || (hdr_valid && hdr_sof))); // R12
   AST_TCI_NEVER_TYPE: assert property (@(posedge clk) disable iff (!rst_n)
      (open_q && walk_q == WALK_TCI && !hdr_sof) |-> !et_valid); // R9
endmodule

// File: rtl/rpc_etype_match.sv
module rpc_etype_match #(
   parameter int WORD_W = 16,
   parameter int NUM_TS = 2
) (
   input  logic [WORD_W-1:0]             et_word,
   input  logic [WORD_W-1:0]             ring_type,
   input  logic [NUM_TS-1:0][WORD_W-1:0] ts_types,
   output logic                          ring_hit,
   output logic                          ts_hit
);
   if (NUM_TS < 1) begin : g_bad_ts
      $error("rpc_etype_match: NUM_TS must be at least 1");
   end

   logic [NUM_TS-1:0] ts_each;

   for (genvar i = 0; i < NUM_TS; i++) begin : g_ts
      assign ts_each[i] = (et_word == ts_types[i]);
   end

   assign ring_hit = (et_word == ring_type);
   assign ts_hit   = |ts_each;
endmodule

// File: rtl/rpc_prio_decide.sv
module rpc_prio_decide #(
   parameter int PORT_W    = 2,
   parameter int PRIO_W    = 2,
   parameter int HOST_PORT = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              et_valid,
   input  logic              ring_hit,
   input  logic              ts_hit,
   input  logic              ring_en,
   input  logic [PORT_W-1:0] et_port,
   input  logic [PRIO_W-1:0] et_prio,
   output logic              res_valid,
   output logic [PRIO_W-1:0] res_prio,
   output logic              res_host_chan,
   output logic              res_tsync
);
   localparam logic [PRIO_W-1:0] TOP_PRIO = {PRIO_W{1'b1}};
   localparam logic [PORT_W-1:0] HOST_ID  = PORT_W'(HOST_PORT);

   if (HOST_PORT < 0 || HOST_PORT >= (1 << PORT_W)) begin : g_bad_host
      $error("rpc_prio_decide: HOST_PORT out of range for PORT_W");
   end

   logic ring_act;
   assign ring_act = ring_en && ring_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid     <= 1'b0;
         res_prio      <= '0;
         res_host_chan <= 1'b0;
         res_tsync     <= 1'b0;
      end else begin
         res_valid <= et_valid;
         if (et_valid) begin
            res_prio      <= ring_act ? TOP_PRIO : et_prio;
            res_host_chan <= ring_act && (et_port == HOST_ID);
            res_tsync     <= ts_hit;
         end
      end
   end

   AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      et_valid |=> res_valid); // R2
   AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
      !et_valid |=> !res_valid); // R2
   AST_HOST_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      et_valid && !ring_en |=> !res_host_chan); // R3
   AST_HOST_TOP_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_host_chan) |-> (res_prio == TOP_PRIO)); // R4
   AST_HOST_PORT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      et_valid && (et_port != HOST_ID) |=> !res_host_chan); // R5
endmodule

// File: rtl/rpc_classifier.sv
module rpc_classifier
   import rpc_pkg::*;
#(
   parameter int PORT_W     = 2,
   parameter int PRIO_W     = 2,
   parameter int TAG_LEVELS = 2,
   parameter int HOST_PORT  = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               hdr_valid,
   input  logic               hdr_sof,
   input  logic [ETYPE_W-1:0] hdr_word,
   input  logic [PORT_W-1:0]  dest_port,
   input  logic [PRIO_W-1:0]  frame_prio,
   input  logic               ring_en,
   input  logic [ETYPE_W-1:0] ring_etype,
   input  logic [ETYPE_W-1:0] tsync_etype_a,
   input  logic [ETYPE_W-1:0] tsync_etype_b,
   input  logic [ETYPE_W-1:0] vtag_outer,
   input  logic [ETYPE_W-1:0] vtag_inner,
   output logic               res_valid,
   output logic [PRIO_W-1:0]  res_prio,
   output logic               res_host_chan,
   output logic               res_tsync
);
   localparam int NUM_TS = 2;

   logic               et_valid;
   logic [ETYPE_W-1:0] et_word;
   logic [PORT_W-1:0]  et_port;
   logic [PRIO_W-1:0]  et_prio;
   logic               ring_hit;
   logic               ts_hit;
   logic [NUM_TS-1:0][ETYPE_W-1:0] ts_types;

   assign ts_types = {tsync_etype_b, tsync_etype_a};

   rpc_tag_walker #(
      .WORD_W(ETYPE_W), .TAG_LEVELS(TAG_LEVELS), .PORT_W(PORT_W), .PRIO_W(PRIO_W)
   ) u_walker (
      .clk(clk), .rst_n(rst_n),
      .hdr_valid(hdr_valid), .hdr_sof(hdr_sof), .hdr_word(hdr_word),
      .tag_outer(vtag_outer), .tag_inner(vtag_inner),
      .in_port(dest_port), .in_prio(frame_prio),
      .et_valid(et_valid), .et_word(et_word), .et_port(et_port), .et_prio(et_prio)
   );

   rpc_etype_match #(
      .WORD_W(ETYPE_W), .NUM_TS(NUM_TS)
   ) u_match (
      .et_word(et_word), .ring_type(ring_etype), .ts_types(ts_types),
      .ring_hit(ring_hit), .ts_hit(ts_hit)
   );

   rpc_prio_decide #(
      .PORT_W(PORT_W), .PRIO_W(PRIO_W), .HOST_PORT(HOST_PORT)
   ) u_decide (
      .clk(clk), .rst_n(rst_n),
      .et_valid(et_valid), .ring_hit(ring_hit), .ts_hit(ts_hit), .ring_en(ring_en),
      .et_port(et_port), .et_prio(et_prio),
      .res_valid(res_valid), .res_prio(res_prio),
      .res_host_chan(res_host_chan), .res_tsync(res_tsync)
   );

   AST_TSYNC_ANY_EN: assert property (@(posedge clk) disable iff (!rst_n)
      (et_valid && (et_word == tsync_etype_a || et_word == tsync_etype_b)) |=> res_tsync); // R7
endmodule

// File: tb/rpc_classifier_tb.sv
module rpc_classifier_tb;
   localparam int VW = 92;
   localparam int NV = 12;
   // {en, port, prio, nwords, w0, w1, w2, w3, w4, exp_prio, exp_host, exp_ts}
   localparam logic [VW-1:0] VEC [NV] = '{
      {1'b1,2'd0,2'd1,3'd1,16'h80E1,16'h0,16'h0,16'h0,16'h0,2'd3,1'b1,1'b0}, // R4 R5
      {1'b1,2'd1,2'd0,3'd1,16'h80E1,16'h0,16'h0,16'h0,16'h0,2'd3,1'b0,1'b0}, // R5
      {1'b0,2'd0,2'd1,3'd1,16'h80E1,16'h0,16'h0,16'h0,16'h0,2'd1,1'b0,1'b0}, // R3
      {1'b1,2'd2,2'd2,3'd1,16'h0800,16'h0,16'h0,16'h0,16'h0,2'd2,1'b0,1'b0}, // R6
      {1'b1,2'd0,2'd0,3'd1,16'h88F7,16'h0,16'h0,16'h0,16'h0,2'd0,1'b0,1'b1}, // R7
      {1'b0,2'd3,2'd2,3'd1,16'h22F0,16'h0,16'h0,16'h0,16'h0,2'd2,1'b0,1'b1}, // R7
      {1'b1,2'd0,2'd1,3'd3,16'h88A8,16'h0005,16'h80E1,16'h0,16'h0,2'd3,1'b1,1'b0}, // R9
      {1'b1,2'd0,2'd2,3'd5,16'h88A8,16'h0007,16'h8100,16'h0009,16'h80E1,2'd3,1'b1,1'b0}, // R10
      {1'b1,2'd0,2'd2,3'd1,16'h8100,16'h0,16'h0,16'h0,16'h0,2'd2,1'b0,1'b0}, // R10
      {1'b1,2'd1,2'd3,3'd3,16'h88A8,16'h80E1,16'h88F7,16'h0,16'h0,2'd3,1'b0,1'b1}, // R9
      {1'b1,2'd0,2'd0,3'd5,16'h88A8,16'h0001,16'h8100,16'h0002,16'h88A8,2'd0,1'b0,1'b0}, // R11
      {1'b1,2'd0,2'd3,3'd3,16'h88A8,16'h0000,16'h0800,16'h0,16'h0,2'd3,1'b0,1'b0}  // R6 R13
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        hdr_valid = 1'b0;
   logic        hdr_sof = 1'b0;
   logic [15:0] hdr_word = '0;
   logic [1:0]  dest_port = '0;
   logic [1:0]  frame_prio = '0;
   logic        ring_en = 1'b0;
   logic [15:0] ring_etype = 16'h80E1;
   logic [15:0] tsync_etype_a = 16'h88F7;
   logic [15:0] tsync_etype_b = 16'h22F0;
   logic [15:0] vtag_outer = 16'h88A8;
   logic [15:0] vtag_inner = 16'h8100;
   logic        res_valid;
   logic [1:0]  res_prio;
   logic        res_host_chan;
   logic        res_tsync;

   int checks = 0;
   int failures = 0;

   always #5 clk = ~clk;

   rpc_classifier u_dut (
      .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .hdr_sof(hdr_sof),
      .hdr_word(hdr_word), .dest_port(dest_port), .frame_prio(frame_prio),
      .ring_en(ring_en), .ring_etype(ring_etype), .tsync_etype_a(tsync_etype_a),
      .tsync_etype_b(tsync_etype_b), .vtag_outer(vtag_outer), .vtag_inner(vtag_inner),
      .res_valid(res_valid), .res_prio(res_prio), .res_host_chan(res_host_chan),
      .res_tsync(res_tsync)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic check_result(input string req, input logic [1:0] ep, input logic eh, input logic et);
      chk(res_valid == 1'b1, {req, " valid"}, 32'(res_valid), 32'd1);
      chk(res_prio == ep, {req, " prio"}, 32'(res_prio), 32'(ep));
      chk(res_host_chan == eh, {req, " host"}, 32'(res_host_chan), 32'(eh));
      chk(res_tsync == et, {req, " tsync"}, 32'(res_tsync), 32'(et));
   endtask

   task automatic run_frame(input logic [VW-1:0] v, input string req);
      logic [2:0] nw;
      bit early;
      nw = v[86:84];
      early = 1'b0;
      for (int i = 0; i < int'(nw); i++) begin
         @(negedge clk);
         if (res_valid) early = 1'b1;
         ring_en    = v[91];
         hdr_valid  = 1'b1;
         hdr_sof    = (i == 0);
         hdr_word   = v[83 - 16*i -: 16];
         dest_port  = (i == 0) ? v[90:89] : ~v[90:89];  // R13 scramble
         frame_prio = (i == 0) ? v[88:87] : ~v[88:87];
      end
      @(negedge clk);
      hdr_valid = 1'b0;
      hdr_sof   = 1'b0;
      chk(!early, {req, " R2 no early result"}, 32'(early), 32'd0);
      check_result(req, v[3:2], v[1], v[0]);
      @(negedge clk);
      chk(res_valid == 1'b0, {req, " R2 single pulse"}, 32'(res_valid), 32'd0);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin : main
      // R1: reset holds outputs at zero even with traffic present
      hdr_valid = 1'b1; hdr_sof = 1'b1; hdr_word = 16'h80E1; ring_en = 1'b1;
      repeat (3) @(negedge clk);
      chk(res_valid == 0 && res_prio == 0 && res_host_chan == 0 && res_tsync == 0,
          "R1 during reset", {28'd0, res_valid, res_prio, res_host_chan}, 32'd0);
      hdr_valid = 1'b0; hdr_sof = 1'b0;
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(res_valid == 0 && res_prio == 0 && res_host_chan == 0 && res_tsync == 0,
          "R1 after reset", {28'd0, res_valid, res_prio, res_host_chan}, 32'd0);

      for (int k = 0; k < NV; k++) begin
         run_frame(VEC[k], $sformatf("vec%0d", k));
      end

      // R8: ring and time-sync both match
      tsync_etype_b = 16'h80E1;
      run_frame({1'b1,2'd0,2'd0,3'd1,16'h80E1,16'h0,16'h0,16'h0,16'h0,2'd3,1'b1,1'b1}, "R8 both");
      tsync_etype_b = 16'h22F0;

      // R12: stray words with no frame open
      @(negedge clk);
      hdr_valid = 1'b1; hdr_sof = 1'b0; hdr_word = 16'h80E1;
      @(negedge clk);
      chk(res_valid == 0, "R12 stray word 1", 32'(res_valid), 32'd0);
      @(negedge clk);
      chk(res_valid == 0, "R12 stray word 2", 32'(res_valid), 32'd0);
      hdr_valid = 1'b0;

      // R12 R13: restart in the middle of a tag
      @(negedge clk);
      ring_en = 1'b1;
      hdr_valid = 1'b1; hdr_sof = 1'b1; hdr_word = 16'h88A8; dest_port = 2'd1; frame_prio = 2'd0;
      @(negedge clk);
      hdr_sof = 1'b1; hdr_word = 16'h80E1; dest_port = 2'd0; frame_prio = 2'd2;
      @(negedge clk);
      hdr_valid = 1'b0; hdr_sof = 1'b0;
      check_result("R12 restart", 2'd3, 1'b1, 1'b0);

      // R10 R12: inner type at top level closes the frame; a trailing word is ignored
      @(negedge clk);
      hdr_valid = 1'b1; hdr_sof = 1'b1; hdr_word = 16'h8100; dest_port = 2'd0; frame_prio = 2'd1;
      @(negedge clk);
      hdr_sof = 1'b0; hdr_word = 16'h80E1;
      check_result("R10 inner at top", 2'd1, 1'b0, 1'b0);
      @(negedge clk);
      hdr_valid = 1'b0;
      chk(res_valid == 0, "R12 word after close", 32'(res_valid), 32'd0);

      repeat (2) @(negedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule